// File: doc/BRIEF.md
# Programmable Address Window Decoder

The decoder compares the upper half of a 32-bit bus address (the 64 KB page number) with a small set of programmable windows. Each window has a base word and a size-mask word. A single shared control word carries two things: one enable bit for each window, and a 2-bit access-permission field for each window. For every lookup the block reports one of three outcomes a cycle later. The outcome is a permitted hit, a protection error, or a miss. With a hit or a protection error it also reports the index of the selected window and that window's 8-bit target/attribute code.

Software reaches every register through a flat word-indexed configuration port, with a combinational read path. This lets it save the full decoder setup and write it back unchanged. An override word can force one chosen window for every lookup. The enables and the address comparison are then ignored, but the permission check still applies.

The default configuration has five windows: four chip-select windows and one extra window. The override index field sits below bit 8 and the permission fields must fit in bits [31:16], so the window count must lie between 2 and 8.

Top module: `win_decoder`

## Requirements
- R1: After reset every register reads 0, so no window is enabled and no override is active. Every lookup then misses.
- R2: The configuration index map is: 0 = control, 1 = override, 2+i = base of window i, 2+NWIN+i = size mask of window i. A write stores all 32 bits and reads back unchanged on `cfg_rdata` for the index on `cfg_addr`. An index of 2+2*NWIN or above reads 0, and a write to it changes no register.
- R3: Window i matches when control bit i is 1 and `lk_page` equals base[31:16] in every bit where mask[31:16] holds 0. The mask bits give the window size in 64 KB units minus one.
- R4: When several windows match, the one with the lowest index is selected.
- R5: A lookup that selects no window gives `res_miss`=1, with `res_hit`=0, `res_perm_err`=0, `res_win`=0 and `res_attr`=0.
- R6: For a selected window, `res_win` is its index and `res_attr` is bits [15:8] of its base word.
- R7: The permission of window i sits in control bits [17+2i:16+2i]. The lower bit allows reads and the upper bit allows writes, so 3 grants both. If the access type on `lk_write` is allowed, the result is `res_hit`=1. Otherwise the result is `res_perm_err`=1 with `res_hit`=0.
- R8: Override bit 8 set, with override bits [2:0] below NWIN, selects that window for every lookup, regardless of its enable bit and of address match. An index of NWIN or above gives a miss. Writing 0 to the override register restores normal decoding.
- R9: Results are registered. `res_valid` equals `lk_valid` of the previous cycle. When `res_valid` is 0, all outcome flags are 0.
- R10: A lookup decodes against the register values held before any write made in the same cycle. A write is seen by lookups from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register index |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Contents of the register at `cfg_addr` |
| lk_valid | input | 1 | Lookup request |
| lk_page | input | 16 | Address bits [31:16] of the lookup |
| lk_write | input | 1 | 1 = write access, 0 = read access |
| res_valid | output | 1 | Result present (lookup of previous cycle) |
| res_hit | output | 1 | Permitted hit |
| res_miss | output | 1 | No window selected |
| res_perm_err | output | 1 | Window selected but access type not permitted |
| res_win | output | 3 | Index of selected window |
| res_attr | output | 8 | Attribute code of selected window |

## Verification
The bench sets up overlapping windows in which a lower-indexed window shadows a higher one. A decoder with reversed priority would report the wrong index and the wrong attribute there. It tests read-only and write-only permissions under both access types. A swapped read/write bit would then show up as a hit where a protection error is due, or the other way round. It forces in-range and out-of-range override indices, which would expose an override that honoured the enable bit or that aliased an illegal index onto a real window. Write-and-lookup in the same cycle, mask bits that widen a window, and writes to unmapped indices are also exercised. They would catch bypassed write data, a reversed mask polarity, and a register-map decode that wraps.

// File: rtl/win_pkg.sv
package win_pkg;
  localparam int WIN_LSB    = 16;  // page field starts here in base/mask words
  localparam int PERM_LSB   = 16;  // permission fields start here in control word
  localparam int ATTR_LSB   = 8;   // attribute byte in base word
  localparam int OVR_EN_BIT = 8;   // override enable bit
  localparam int REG_CTRL   = 0;
  localparam int REG_OVRD   = 1;
  localparam int REG_BASE0  = 2;

  function automatic logic perm_allows(input logic [1:0] perm, input logic is_write);
    return is_write ? perm[1] : perm[0];
  endfunction
endpackage

// File: rtl/win_regfile.sv
module win_regfile
  import win_pkg::*;
#(
  parameter int NWIN = 5,
  parameter int DW   = 32,
  localparam int NREG = 2 * NWIN + 2,
  localparam int RAW  = $clog2(NREG),
  localparam int IW   = $clog2(NWIN),
  localparam int HW   = DW - WIN_LSB
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [RAW-1:0]           addr,
  input  logic [DW-1:0]            wdata,
  output logic [DW-1:0]            rdata,
  output logic [NWIN-1:0]          win_en,
  output logic [2*NWIN-1:0]        win_perm,
  output logic                     ovr_en,
  output logic [IW-1:0]            ovr_idx,
  output logic [NWIN-1:0][HW-1:0]  base_hi,
  output logic [NWIN-1:0][7:0]     base_attr,
  output logic [NWIN-1:0][HW-1:0]  mask_hi
);

  logic [DW-1:0]           ctrl_q, ovrd_q;
  logic [NWIN-1:0][DW-1:0] base_q, mask_q;
  logic                    ctrl_we, ovrd_we;
  logic [NWIN-1:0]         base_we, mask_we;

  // write decode
  always_comb begin
    ctrl_we = we && (addr == RAW'(REG_CTRL));
    ovrd_we = we && (addr == RAW'(REG_OVRD));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_we) begin
      ctrl_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovrd_q <= '0;
    end else if (ovrd_we) begin
      ovrd_q <= wdata;
    end
  end

  for (genvar i = 0; i < NWIN; i++) begin : g_win_regs
    assign base_we[i] = we && (addr == RAW'(REG_BASE0 + i));
    assign mask_we[i] = we && (addr == RAW'(REG_BASE0 + NWIN + i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q[i] <= '0;
      end else if (base_we[i]) begin
        base_q[i] <= wdata;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mask_q[i] <= '0;
      end else if (mask_we[i]) begin
        mask_q[i] <= wdata;
      end
    end

    assign base_hi[i]   = base_q[i][DW-1:WIN_LSB];
    assign base_attr[i] = base_q[i][ATTR_LSB +: 8];
    assign mask_hi[i]   = mask_q[i][DW-1:WIN_LSB];
  end

  // read mux
  always_comb begin
    rdata = '0;
    if (addr == RAW'(REG_CTRL)) rdata = ctrl_q;
    if (addr == RAW'(REG_OVRD)) rdata = ovrd_q;
    for (int i = 0; i < NWIN; i++) begin
      if (addr == RAW'(REG_BASE0 + i))        rdata = base_q[i];
      if (addr == RAW'(REG_BASE0 + NWIN + i)) rdata = mask_q[i];
    end
  end

  assign win_en   = ctrl_q[NWIN-1:0];
  assign win_perm = ctrl_q[PERM_LSB +: 2*NWIN];
  assign ovr_en   = ovrd_q[OVR_EN_BIT];
  assign ovr_idx  = ovrd_q[IW-1:0];

  AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> (ctrl_q == $past(wdata))) else $error("control write lost"); // R2
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(addr) >= NREG) |-> (rdata == '0)) else $error("unmapped read not zero"); // R2

endmodule

// File: rtl/win_match.sv
module win_match
  import win_pkg::*;
#(
  parameter int NWIN = 5,
  parameter int DW   = 32,
  localparam int HW  = DW - WIN_LSB
) (
  input  logic [HW-1:0]            page,
  input  logic [NWIN-1:0]          win_en,
  input  logic [NWIN-1:0][HW-1:0]  base_hi,
  input  logic [NWIN-1:0][HW-1:0]  mask_hi,
  output logic [NWIN-1:0]          match
);

  for (genvar i = 0; i < NWIN; i++) begin : g_cmp
    logic [HW-1:0] care;
    assign care     = ~mask_hi[i];
    assign match[i] = win_en[i] && ((page & care) == (base_hi[i] & care));
  end

endmodule

// File: rtl/win_select.sv
module win_select #(
  parameter int NWIN = 5,
  localparam int IW  = $clog2(NWIN)
) (
  input  logic [NWIN-1:0] match,
  input  logic            ovr_en,
  input  logic [IW-1:0]   ovr_idx,
  output logic            any,
  output logic [IW-1:0]   idx
);

  always_comb begin
    any = 1'b0;
    idx = '0;
    if (ovr_en) begin
      if (int'(ovr_idx) < NWIN) begin
        any = 1'b1;
        idx = ovr_idx;
      end
    end else begin
      for (int w = NWIN - 1; w >= 0; w--) begin
        if (match[w]) begin
          any = 1'b1;
          idx = IW'(w);
        end
      end
    end
  end

  // no lower-indexed window may match the one chosen
  always_comb begin
    if (!ovr_en && any) begin
      AST_PRIO_LOWEST: assert ((match & ((NWIN'(1) << idx) - NWIN'(1))) == '0); // R4
    end
  end

endmodule

// File: rtl/win_decoder.sv
module win_decoder
  import win_pkg::*;
#(
  parameter int NWIN = 5,
  localparam int DW  = 32,
  localparam int RAW = $clog2(2 * NWIN + 2),
  localparam int IW  = $clog2(NWIN),
  localparam int HW  = DW - WIN_LSB
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [RAW-1:0] cfg_addr,
  input  logic [DW-1:0]  cfg_wdata,
  output logic [DW-1:0]  cfg_rdata,
  input  logic           lk_valid,
  input  logic [HW-1:0]  lk_page,
  input  logic           lk_write,
  output logic           res_valid,
  output logic           res_hit,
  output logic           res_miss,
  output logic           res_perm_err,
  output logic [IW-1:0]  res_win,
  output logic [7:0]     res_attr
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  logic [NWIN-1:0]         win_en;
  logic [2*NWIN-1:0]       win_perm;
  logic                    ovr_en;
  logic [IW-1:0]           ovr_idx;
  logic [NWIN-1:0][HW-1:0] base_hi, mask_hi;
  logic [NWIN-1:0][7:0]    base_attr;
  logic [NWIN-1:0]         match;
  logic                    sel_any;
  logic [IW-1:0]           sel_idx;

  win_regfile #(.NWIN(NWIN), .DW(DW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .we        (cfg_we),
    .addr      (cfg_addr),
    .wdata     (cfg_wdata),
    .rdata     (cfg_rdata),
    .win_en    (win_en),
    .win_perm  (win_perm),
    .ovr_en    (ovr_en),
    .ovr_idx   (ovr_idx),
    .base_hi   (base_hi),
    .base_attr (base_attr),
    .mask_hi   (mask_hi)
  );

  win_match #(.NWIN(NWIN), .DW(DW)) u_match (
    .page    (lk_page),
    .win_en  (win_en),
    .base_hi (base_hi),
    .mask_hi (mask_hi),
    .match   (match)
  );

  win_select #(.NWIN(NWIN)) u_sel (
    .match   (match),
    .ovr_en  (ovr_en),
    .ovr_idx (ovr_idx),
    .any     (sel_any),
    .idx     (sel_idx)
  );

  // next-state of result stage
  logic          nxt_valid, nxt_hit, nxt_miss, nxt_err;
  logic [IW-1:0] nxt_win;
  logic [7:0]    nxt_attr;
  logic [1:0]    sel_perm;
  logic          allowed;

  always_comb begin
    sel_perm  = win_perm[2*int'(sel_idx) +: 2];
    allowed   = perm_allows(sel_perm, lk_write);
    nxt_valid = lk_valid;
    nxt_hit   = lk_valid && sel_any && allowed;
    nxt_err   = lk_valid && sel_any && !allowed;
    nxt_miss  = lk_valid && !sel_any;
    nxt_win   = '0;
    nxt_attr  = '0;
    if (lk_valid && sel_any) begin
      nxt_win  = sel_idx;
      nxt_attr = base_attr[sel_idx];
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      res_valid    <= 1'b0;
      res_hit      <= 1'b0;
      res_miss     <= 1'b0;
      res_perm_err <= 1'b0;
      res_win      <= '0;
      res_attr     <= '0;
    end else begin
      res_valid    <= nxt_valid;
      res_hit      <= nxt_hit;
      res_miss     <= nxt_miss;
      res_perm_err <= nxt_err;
      res_win      <= nxt_win;
      res_attr     <= nxt_attr;
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_int_n)
    lk_valid |=> res_valid) else $error("result missing"); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_int_n)
    !res_valid |-> !(res_hit || res_miss || res_perm_err)) else $error("flag without result"); // R9
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_int_n)
    res_valid |-> ($countones({res_hit, res_miss, res_perm_err}) == 1)) else $error("outcome count"); // R7
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_int_n)
    res_miss |-> (res_win == '0 && res_attr == '0)) else $error("miss carries data"); // R5
  AST_OVRD_FORCE: assert property (@(posedge clk) disable iff (!rst_int_n)
    (lk_valid && ovr_en && int'(ovr_idx) < NWIN) |=> (!res_miss && res_win == $past(ovr_idx)))
    else $error("override ignored"); // R8
  AST_DISABLED_MISS: assert property (@(posedge clk) disable iff (!rst_int_n)
    (lk_valid && !ovr_en && win_en == '0) |=> res_miss) else $error("hit with no window"); // R3

endmodule

// File: tb/test_win_decoder.sv
`timescale 1ns/1ps
module test_win_decoder;

  localparam int NW   = 5;
  localparam int NREG = 2 * NW + 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [3:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic        lk_valid;
  logic [15:0] lk_page;
  logic        lk_write;
  logic        res_valid, res_hit, res_miss, res_perm_err;
  logic [2:0]  res_win;
  logic [7:0]  res_attr;

  always #4 clk = ~clk;

  win_decoder #(.NWIN(NW)) i_win_decoder (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .lk_valid(lk_valid),
    .lk_page(lk_page), .lk_write(lk_write), .res_valid(res_valid),
    .res_hit(res_hit), .res_miss(res_miss), .res_perm_err(res_perm_err),
    .res_win(res_win), .res_attr(res_attr)
  );

  int checks = 0;
  int fails  = 0;
  bit chk_on = 0;
  bit done   = 0;

  // behavioural model state
  logic [31:0] m_reg [NREG];
  logic        e_valid, e_hit, e_miss, e_err;
  logic [2:0]  e_win;
  logic [7:0]  e_attr;

  task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // model: decode with pre-write values (R10), then apply write
  always @(posedge clk) begin
    int sel;
    logic [1:0] p;
    bit ok;
    e_valid = lk_valid; e_hit = 0; e_miss = 0; e_err = 0; e_win = 0; e_attr = 0;
    if (lk_valid) begin
      sel = -1;
      if (m_reg[1][8]) begin
        if (m_reg[1][2:0] < NW) sel = m_reg[1][2:0];
      end else begin
        for (int w = 0; w < NW; w++)
          if (sel < 0 && m_reg[0][w] &&
              (((lk_page ^ m_reg[2+w][31:16]) & ~m_reg[2+NW+w][31:16]) == 16'h0))
            sel = w;
      end
      if (sel < 0) e_miss = 1;
      else begin
        p = m_reg[0][16 + 2*sel +: 2];
        ok = lk_write ? p[1] : p[0];
        e_hit = ok; e_err = !ok;
        e_win = 3'(sel); e_attr = m_reg[2+sel][15:8];
      end
    end
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) m_reg[r] = 0;
    end else if (cfg_we && cfg_addr < NREG) begin
      m_reg[cfg_addr] = cfg_wdata;
    end
  end

  always @(negedge clk) begin
    if (chk_on) begin
      cmp("R9 res_valid", 32'(res_valid), 32'(e_valid));
      cmp("R7 res_hit", 32'(res_hit), 32'(e_hit));
      cmp("R7 res_perm_err", 32'(res_perm_err), 32'(e_err));
      cmp("R5 res_miss", 32'(res_miss), 32'(e_miss));
      cmp("R6 res_win", 32'(res_win), 32'(e_win));
      cmp("R6 res_attr", 32'(res_attr), 32'(e_attr));
      cmp("R2 cfg_rdata", cfg_rdata, (cfg_addr < NREG) ? m_reg[cfg_addr] : 32'h0);
    end
  end

  task automatic cyc(input bit we, input int a, input logic [31:0] wd,
                     input bit lv, input logic [15:0] pg, input bit wr);
    @(posedge clk); #2;
    cfg_we = we; cfg_addr = 4'(a); cfg_wdata = wd;
    lk_valid = lv; lk_page = pg; lk_write = wr;
  endtask

  task automatic wreg(input int a, input logic [31:0] wd);
    cyc(1, a, wd, 0, 16'h0, 0);
  endtask

  task automatic look(input logic [15:0] pg, input bit wr);
    cyc(0, 0, 0, 1, pg, wr);
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 0; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
    lk_valid = 0; lk_page = 0; lk_write = 0;
    repeat (5) @(posedge clk);
    #2 rst_n = 1;
    repeat (3) @(posedge clk);
    chk_on = 1;

    // R1: all registers zero, lookups miss
    for (int r = 0; r < 16; r++) cyc(0, r, 0, 1, 16'(r * 4099), r[0]);

    // R2: program four chip-select windows and the extra window
    wreg(2, 32'h0000_0E00); wreg(3, 32'h1000_0D00);
    wreg(4, 32'h2000_0B00); wreg(5, 32'h3000_0700);
    wreg(6, 32'h4000_1E00);
    for (int w = 0; w < 4; w++) wreg(7 + w, 32'h0FFF_0000);
    wreg(11, 32'h03FF_0000);
    wreg(0, 32'h0000_0000);
    // R3: windows still disabled -> miss
    look(16'h0000, 0); look(16'h4000, 1);
    wreg(0, 32'h03FF_001F);
    // R2: unmapped indices ignore writes and read zero
    wreg(12, 32'hDEAD_BEEF); wreg(15, 32'hFFFF_FFFF);
    for (int r = 0; r < 16; r++) cyc(0, r, 0, 0, 0, 0);

    // R3, R6: hits inside each window, edges and outside
    look(16'h0000, 0); look(16'h0FFF, 1); look(16'h1000, 0);
    look(16'h2ABC, 1); look(16'h3FFF, 0); look(16'h4000, 0);
    look(16'h43FF, 1); look(16'h4400, 0); look(16'h8000, 0); look(16'hFFFF, 1);

    // R4: overlapping windows, lowest index wins
    wreg(3, 32'h0000_0D00);
    look(16'h0123, 0);
    wreg(0, 32'h03FF_001E);   // disable window 0
    look(16'h0123, 0);
    wreg(0, 32'h03FF_001F); wreg(3, 32'h1000_0D00);

    // R7: read-only on window 2, write-only on window 3, none on window 4
    wreg(0, {6'h0, 2'b00, 2'b10, 2'b01, 2'b11, 2'b11, 16'h001F});
    look(16'h2000, 0); look(16'h2000, 1);
    look(16'h3000, 0); look(16'h3000, 1);
    look(16'h4000, 0); look(16'h4000, 1);
    wreg(0, 32'h03FF_001F);

    // R8: forced window, out-of-range index, then cleared
    wreg(1, 32'h0000_0103);
    look(16'h8888, 0); look(16'h0000, 1);
    wreg(0, 32'h03FF_0000);   // enables off: override still forces
    look(16'h1234, 0);
    wreg(1, 32'h0000_0107);
    look(16'h3000, 0);
    wreg(1, 32'h0000_0000);
    wreg(0, 32'h03FF_001F);
    look(16'h3000, 0);

    // R10: write and lookup in the same cycle
    cyc(1, 0, 32'h03FF_0000, 1, 16'h1000, 0);
    look(16'h1000, 0);
    cyc(1, 0, 32'h03FF_001F, 1, 16'h1000, 1);
    look(16'h1000, 1);

    // mixed random traffic
    for (int n = 0; n < 600; n++) begin
      logic [31:0] rv;
      int a;
      bit we;
      rv = $urandom;
      we = ($urandom % 6) == 0;
      a  = $urandom % 16;
      if (a == 1) rv = rv & 32'h0000_0107;
      cyc(we, a, rv, $urandom % 4 != 0,
          ($urandom % 2) ? 16'($urandom) : {1'b0, 3'($urandom % 5), 12'($urandom)},
          $urandom % 2);
    end
    cyc(0, 0, 0, 0, 0, 0);
    @(posedge clk); @(negedge clk); #1;
    done = 1;
    summary();
    $finish;
  end

endmodule